// File: doc/BRIEF.md
# Packet Receive Buffer with Read-Enable Streaming Output

This block sits on the receive side of a packet link. It stores whole command/data packets that arrive one 64-bit word per cycle on a write port. Each packet carries start and end markers and a 3-bit region-match tag on its first word. A downstream master drains the stored packets over a streaming read port. The master raises a read-enable level. In the cycle after the master samples that level high, the buffer presents one word together with its valid, start, end and tag outputs. While read-enable is low, every output keeps its value.

Data-available tells the master that at least one complete packet is waiting. A packet counts as complete once its end word has been written. The count drops when that end word leaves on the read port. Packets are released only as whole units. While read-enable stays high, the words of a packet come out on consecutive cycles. The next packet follows directly after the end word.

A two-state read controller governs the read side. `ST_IDLE` means the read side sits between packets. From `ST_IDLE`, a new packet may begin only when the complete-packet count is non-zero. The transition `IDLE->MID` fires when a start word that is not also an end word is popped. `ST_MID` means a packet is partly delivered, and its remaining words may be popped freely. The transition `MID->IDLE` fires when the end word is popped. A single-word packet leaves the controller in `ST_IDLE`.

Top module: `pkt_rx_buf`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, rd_val, rd_sop, rd_eop, rd_dav and wr_full are all 0.
- R2: If rd_en is high at a clock edge and a deliverable word is stored, that word appears on rd_data with rd_val=1 right after that edge, one cycle after rd_en was presented.
- R3: At an edge where rd_en is low, rd_val, rd_sop, rd_eop, rd_tag and rd_data keep their previous values.
- R4: If rd_en is high at an edge and no deliverable word is stored, rd_val, rd_sop and rd_eop become 0. No earlier word is repeated.
- R5: rd_dav is 1 exactly when at least one packet has had its end word written but has not yet had that end word read. A packet whose end word is still missing does not raise rd_dav and is not delivered.
- R6: With rd_en held high, the words of a packet come out in write order on consecutive cycles, each with rd_val=1.
- R7: If rd_en is high when the end word of a packet is delivered and another complete packet is stored, that packet's first word comes out on the very next cycle.
- R8: rd_tag equals the wr_tag written with the packet's start word and is meaningful only while rd_val and rd_sop are both 1. Codes 0 to 5 name match regions 0 to 5, code 7 marks a packet without an address, and code 6 is unused but passed through unchanged.
- R9: wr_full is 1 exactly when fewer than MAX_PKT word slots are free, that is, when more than DEPTH-MAX_PKT words are stored.
- R10: rd_sop is 1 on the first word of a packet and rd_eop on its last. A one-word packet has both set on the same word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| wr_vld | input | 1 | Write word present this cycle |
| wr_sop | input | 1 | Write word is the first of its packet |
| wr_eop | input | 1 | Write word is the last of its packet |
| wr_tag | input | 3 | Region-match tag, taken from the start word |
| wr_data | input | 64 | Write data word |
| wr_full | output | 1 | Fewer than MAX_PKT free slots remain |
| rd_en | input | 1 | Read enable from the master |
| rd_val | output | 1 | Output word valid |
| rd_sop | output | 1 | Output word starts a packet |
| rd_eop | output | 1 | Output word ends a packet |
| rd_tag | output | 3 | Region-match tag of the packet on the output |
| rd_data | output | 64 | Output data word |
| rd_dav | output | 1 | At least one complete packet is stored |

## Verification
The assertions assume that the writer sends well-formed packets: a start word first, an end word last, and no start word in between. They also assume that the writer stops offering a new packet while wr_full is high. Under those assumptions a packet in `ST_MID` always has its remaining words in storage, and a pop never meets an empty store. The bench follows both rules. It writes each packet completely, always with its start and end markers in place. Before it fills the buffer, it counts the free slots, so it never writes past the full threshold by more than one short packet.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

    localparam int TAG_W = 3;

    // Per-word side information kept next to each stored data word
    typedef struct packed {
        logic             sop;
        logic             eop;
        logic [TAG_W-1:0] tag;
    } meta_t;

    // Read controller position relative to packet boundaries
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_MID  = 1'b1
    } rd_state_e;

endpackage

// File: rtl/pkt_rx_store.sv
module pkt_rx_store
    import pkt_rx_pkg::*;
#(
    parameter int DW    = 64,
    parameter int DEPTH = 32,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  meta_t         push_meta,
    input  logic [DW-1:0] push_data,
    output logic          push_ok,
    input  logic          pop,
    output meta_t         head_meta,
    output logic [DW-1:0] head_data,
    output logic          head_avail,
    output logic [CW-1:0] used
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] CAP      = CW'(DEPTH);

    logic [DW-1:0] mem_d [DEPTH];
    meta_t         mem_m [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;

    assign push_ok    = push && (used != CAP);
    assign head_avail = (used != '0);
    assign head_data  = mem_d[rd_ptr];
    assign head_meta  = mem_m[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem_d[wr_ptr] <= push_data;
            mem_m[wr_ptr] <= push_meta;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            used   <= '0;
        end else begin
            if (push_ok) wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            if (pop)     rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            unique case ({push_ok, pop})
                2'b10:   used <= used + 1'b1;
                2'b01:   used <= used - 1'b1;
                default: used <= used;
            endcase
        end
    end

    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
        pop |-> (used != '0)); // R4

endmodule

// File: rtl/pkt_rx_pktcnt.sv
module pkt_rx_pktcnt #(
    parameter int CW = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          inc,
    input  logic          dec,
    output logic [CW-1:0] cnt,
    output logic          nonzero
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    assign nonzero = (cnt != '0);

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (dec && !inc) |-> (cnt != '0)); // R5

endmodule

// File: rtl/pkt_rx_rdctl.sv
module pkt_rx_rdctl
    import pkt_rx_pkg::*;
#(
    parameter int DW = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rd_en,
    input  logic             pkt_ready,
    input  logic             head_avail,
    input  meta_t            head_meta,
    input  logic [DW-1:0]    head_data,
    output logic             pop,
    output logic             out_val,
    output logic             out_sop,
    output logic             out_eop,
    output logic [TAG_W-1:0] out_tag,
    output logic [DW-1:0]    out_data
);

    rd_state_e state_q, state_d;
    logic      readable;

    // A new packet may start only once it is complete; its remaining words follow freely
    always_comb begin
        unique case (state_q)
            ST_IDLE: readable = pkt_ready && head_avail;
            ST_MID:  readable = head_avail;
        endcase
    end

    assign pop = rd_en && readable;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (pop && head_meta.sop && !head_meta.eop) state_d = ST_MID;
            ST_MID:  if (pop && head_meta.eop)                   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_val  <= 1'b0;
            out_sop  <= 1'b0;
            out_eop  <= 1'b0;
            out_tag  <= '0;
            out_data <= '0;
        end else if (rd_en) begin
            out_val <= pop;
            if (pop) begin
                out_sop  <= head_meta.sop;
                out_eop  <= head_meta.eop;
                out_tag  <= head_meta.tag;
                out_data <= head_data;
            end else begin
                out_sop <= 1'b0;
                out_eop <= 1'b0;
            end
        end
    end

    AST_HOLD_NO_ENABLE: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> ($stable(out_val) && $stable(out_data) && $stable(out_sop)
                    && $stable(out_eop) && $stable(out_tag))); // R3

    AST_NO_GAP_MID: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_MID && rd_en) |=> out_val); // R6

endmodule

// File: rtl/pkt_rx_buf.sv
module pkt_rx_buf
    import pkt_rx_pkg::*;
#(
    parameter int DW      = 64,
    parameter int DEPTH   = 32,
    parameter int MAX_PKT = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_vld,
    input  logic             wr_sop,
    input  logic             wr_eop,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [DW-1:0]    wr_data,
    output logic             wr_full,
    input  logic             rd_en,
    output logic             rd_val,
    output logic             rd_sop,
    output logic             rd_eop,
    output logic [TAG_W-1:0] rd_tag,
    output logic [DW-1:0]    rd_data,
    output logic             rd_dav
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_AT = CW'(DEPTH - MAX_PKT);

    meta_t         wr_meta, hd_meta;
    logic [DW-1:0] hd_data;
    logic          push_ok, hd_avail, pop_w;
    logic [CW-1:0] used, pkt_cnt;

    assign wr_meta = '{sop: wr_sop, eop: wr_eop, tag: wr_tag};

    pkt_rx_store #(.DW(DW), .DEPTH(DEPTH), .CW(CW)) u_store (
        .clk       (clk),
        .rst       (rst),
        .push      (wr_vld),
        .push_meta (wr_meta),
        .push_data (wr_data),
        .push_ok   (push_ok),
        .pop       (pop_w),
        .head_meta (hd_meta),
        .head_data (hd_data),
        .head_avail(hd_avail),
        .used      (used)
    );

    pkt_rx_pktcnt #(.CW(CW)) u_pktcnt (
        .clk    (clk),
        .rst    (rst),
        .inc    (push_ok && wr_eop),
        .dec    (pop_w && hd_meta.eop),
        .cnt    (pkt_cnt),
        .nonzero(rd_dav)
    );

    pkt_rx_rdctl #(.DW(DW)) u_rdctl (
        .clk       (clk),
        .rst       (rst),
        .rd_en     (rd_en),
        .pkt_ready (rd_dav),
        .head_avail(hd_avail),
        .head_meta (hd_meta),
        .head_data (hd_data),
        .pop       (pop_w),
        .out_val   (rd_val),
        .out_sop   (rd_sop),
        .out_eop   (rd_eop),
        .out_tag   (rd_tag),
        .out_data  (rd_data)
    );

    assign wr_full = (used > FULL_AT);

    AST_BACK_TO_BACK: assert property (@(posedge clk) disable iff (rst)
        (rd_en && pop_w && hd_meta.eop && pkt_cnt > CW'(1)) ##1 rd_en
        |=> (rd_val && rd_sop)); // R7

    AST_SOP_CARRIES_TAG: assert property (@(posedge clk) disable iff (rst)
        (rd_en && pop_w && hd_meta.sop) |=> (rd_sop && rd_tag == $past(hd_meta.tag))); // R8

endmodule

// File: tb/pkt_rx_buf_bench.sv
module pkt_rx_buf_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DW         = 64;
    localparam int DEPTH      = 32;
    localparam int MAX_PKT    = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_vld, wr_sop, wr_eop;
    logic [2:0]    wr_tag;
    logic [DW-1:0] wr_data;
    logic          wr_full;
    logic          rd_en;
    logic          rd_val, rd_sop, rd_eop, rd_dav;
    logic [2:0]    rd_tag;
    logic [DW-1:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pkt_rx_buf #(.DW(DW), .DEPTH(DEPTH), .MAX_PKT(MAX_PKT)) u_pkt_rx_buf (
        .clk(clk), .rst(rst),
        .wr_vld(wr_vld), .wr_sop(wr_sop), .wr_eop(wr_eop), .wr_tag(wr_tag),
        .wr_data(wr_data), .wr_full(wr_full),
        .rd_en(rd_en), .rd_val(rd_val), .rd_sop(rd_sop), .rd_eop(rd_eop),
        .rd_tag(rd_tag), .rd_data(rd_data), .rd_dav(rd_dav)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(input int p, input int w);
        return {32'(p), 32'(w)} ^ 64'h5A5A_0000_0000_3C3C;
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic put(input int p, input int w, input int len, input logic [2:0] tag);
        wr_vld  = 1'b1;
        wr_sop  = (w == 0);
        wr_eop  = (w == len - 1);
        wr_tag  = tag;
        wr_data = pat(p, w);
        tick();
        wr_vld = 1'b0;
        wr_sop = 1'b0;
        wr_eop = 1'b0;
    endtask

    task automatic get(input int p, input int w, input int len, input logic [2:0] tag);
        rd_en = 1'b1;
        tick();
        chk(rd_val === 1'b1, "R2 word valid one cycle after enable", 64'(rd_val), 64'd1);
        chk(rd_data === pat(p, w), "R6 word order", rd_data, pat(p, w));
        chk(rd_sop === (w == 0), "R10 start marker", 64'(rd_sop), 64'(w == 0));
        chk(rd_eop === (w == len - 1), "R10 end marker", 64'(rd_eop), 64'(w == len - 1));
        if (w == 0) chk(rd_tag === tag, "R8 tag with start word", 64'(rd_tag), 64'(tag));
    endtask

    task automatic hold(input int p, input int w);
        rd_en = 1'b0;
        tick();
        chk(rd_val === 1'b1, "R3 valid held", 64'(rd_val), 64'd1);
        chk(rd_data === pat(p, w), "R3 data held", rd_data, pat(p, w));
        chk(rd_sop === (w == 0), "R3 start held", 64'(rd_sop), 64'(w == 0));
    endtask

    task automatic empty_read();
        rd_en = 1'b1;
        tick();
        chk(rd_val === 1'b0, "R4 valid low when nothing stored", 64'(rd_val), 64'd0);
        chk(rd_sop === 1'b0 && rd_eop === 1'b0, "R4 markers low", {62'd0, rd_sop, rd_eop}, 64'd0);
        chk(rd_dav === 1'b0, "R5 no packet available", 64'(rd_dav), 64'd0);
        rd_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int p;
        p = 0;
        rst = 1'b1; wr_vld = 1'b0; wr_sop = 1'b0; wr_eop = 1'b0;
        wr_tag = '0; wr_data = '0; rd_en = 1'b0;
        repeat (3) tick();
        chk(rd_val === 1'b0 && rd_sop === 1'b0 && rd_eop === 1'b0, "R1 outputs in reset",
            {61'd0, rd_val, rd_sop, rd_eop}, 64'd0);
        rst = 1'b0;
        chk(rd_dav === 1'b0, "R1 dav after reset", 64'(rd_dav), 64'd0);
        chk(wr_full === 1'b0, "R1 full after reset", 64'(wr_full), 64'd0);
        chk(rd_val === 1'b0, "R1 valid after reset", 64'(rd_val), 64'd0);

        empty_read();

        // Sweep packet length 1..MAX_PKT, with and without hold gaps between reads
        for (int gap = 0; gap < 2; gap++) begin
            for (int len = 1; len <= MAX_PKT; len++) begin
                p++;
                for (int w = 0; w < len; w++) begin
                    put(p, w, len, 3'(len));
                    if (w < len - 1) begin
                        chk(rd_dav === 1'b0, "R5 partial packet not available", 64'(rd_dav), 64'd0);
                        if (w == 0) begin
                            rd_en = 1'b1;
                            tick();
                            chk(rd_val === 1'b0, "R5 partial packet not delivered", 64'(rd_val), 64'd0);
                            rd_en = 1'b0;
                        end
                    end
                end
                chk(rd_dav === 1'b1, "R5 complete packet available", 64'(rd_dav), 64'd1);
                for (int w = 0; w < len; w++) begin
                    get(p, w, len, 3'(len));
                    if (gap == 1) hold(p, w);
                end
                empty_read();
            end
        end

        // Fill to the threshold, cross it, then drain everything back to back
        for (int k = 0; k < 3; k++)
            for (int w = 0; w < MAX_PKT; w++) put(100 + k, w, MAX_PKT, 3'(k + 5));
        chk(wr_full === 1'b0, "R9 full low at DEPTH-MAX_PKT words",
            64'(wr_full), 64'(DEPTH - 3 * MAX_PKT < MAX_PKT));
        put(103, 0, 1, 3'd6);
        chk(wr_full === 1'b1, "R9 full high past threshold",
            64'(wr_full), 64'(DEPTH - 3 * MAX_PKT - 1 < MAX_PKT));
        for (int k = 0; k < 3; k++) begin
            for (int w = 0; w < MAX_PKT; w++) begin
                get(100 + k, w, MAX_PKT, 3'(k + 5));
                if (w == 0 && k > 0)
                    chk(rd_sop === 1'b1, "R7 next packet starts right after end", 64'(rd_sop), 64'd1);
            end
        end
        get(103, 0, 1, 3'd6);
        chk(rd_sop === 1'b1 && rd_eop === 1'b1, "R7 R10 one-word packet follows directly",
            {62'd0, rd_sop, rd_eop}, 64'd3);
        chk(wr_full === 1'b0, "R9 full low after drain", 64'(wr_full), 64'd0);
        empty_read();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule